// File: doc/BRIEF.md
# UART FIFO control and receive trigger interrupt

This block holds the FIFO control and receive-interrupt logic of a 16550-style serial controller. It contains a receive FIFO and a transmit FIFO of 16 bytes each, a byte-wide control register, and the logic that produces the data-ready status, the interrupt identification code and the DMA signalling mode. The receive shift register pushes finished characters into the receive FIFO. The CPU pops them and pushes bytes into the transmit FIFO, and the transmit side pops them.

The control register is written with a single strobe. Bit 0 selects FIFO mode or single-byte mode. A write sets the other fields only when it also carries bit 0 = 1. A small mode state machine with the states `MODE_SINGLE` and `MODE_FIFO` owns the control fields and decides when the FIFOs are emptied. Its transitions are:
- enter: in `MODE_SINGLE`, a write with bit 0 = 1. It flushes both FIFOs.
- drop: in `MODE_SINGLE`, a write with bit 0 = 0. It flushes both FIFOs and stays in `MODE_SINGLE`.
- reconfigure: in `MODE_FIFO`, a write with bit 0 = 1. It clears each FIFO only on request.
- leave: in `MODE_FIFO`, a write with bit 0 = 0. It flushes both FIFOs and goes to `MODE_SINGLE`.

The receive-data-available interrupt is level-sensitive. It compares the receive occupancy with a programmable trigger. The line-status condition outranks it.

Top module: `sio_fifo_ctrl`

## Requirements
- R1: After reset the block is in single-byte mode. Both counts are 0, `ctl_rdata` is 0x00, `int_id` is 0x1, and `data_ready`, `rx_overrun` and `dma_mode` are 0.
- R2: The readback `ctl_rdata` places FIFO enable at bit 0, DMA mode select at bit 3 and the trigger select at bits 7:6, with all other bits 0. A write with bit 0 = 1 stores bits 3 and 7:6. A write with bit 0 = 0 clears bit 0 only and leaves bits 3 and 7:6 unchanged.
- R3: Both FIFOs are emptied and the overrun flag is cleared by any write with bit 0 = 0, and by a write with bit 0 = 1 made while FIFO mode is off.
- R4: In a write with bit 0 = 1, bit 1 empties only the receive FIFO and clears overrun, and bit 2 empties only the transmit FIFO. Bits 1 and 2 always read back as 0.
- R5: Capacity is 16 in FIFO mode and 1 in single-byte mode. A receive push to a full FIFO is dropped and sets `rx_overrun`. A transmit push to a full FIFO is dropped.
- R6: A pop presents the oldest byte on `rx_dout`/`tx_dout` after the clock edge. Bytes come out in push order. A pop from an empty FIFO leaves the data output and the count unchanged.
- R7: `data_ready` is 1 exactly when the receive count is non-zero.
- R8: `int_id` is 0x4 when the receive count is at or above the trigger, and 0x1 otherwise. In FIFO mode the trigger select 00/01/10/11 gives 1/4/8/14 bytes. In single-byte mode the trigger is 1.
- R9: `int_id` is 0x6 whenever `rx_overrun` or `rx_line_err` is 1. This takes priority over 0x4.
- R10: `dma_mode` is 1 only when FIFO mode is on and the stored bit 3 is 1.
- R11: A flush in the same cycle as a push discards the push. A push to a full FIFO is dropped even when a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control state readback |
| rx_push | input | 1 | Character from the receive shift register |
| rx_din | input | 8 | Received character |
| rx_line_err | input | 1 | Line status error level from the receiver |
| rx_pop | input | 1 | CPU read of the receive FIFO |
| rx_dout | output | 8 | Last byte popped from the receive FIFO |
| rx_count | output | 5 | Receive FIFO occupancy |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| data_ready | output | 1 | Receive data present |
| tx_push | input | 1 | CPU write to the transmit FIFO |
| tx_din | input | 8 | Transmit byte |
| tx_pop | input | 1 | Transmit side takes a byte |
| tx_dout | output | 8 | Last byte popped from the transmit FIFO |
| tx_count | output | 5 | Transmit FIFO occupancy |
| int_id | output | 4 | Interrupt identification: 0x1 none, 0x4 data available, 0x6 line status |
| dma_mode | output | 1 | DMA signalling mode 1 selected |

## Verification
Two events can land in the same cycle: a control write that empties the receive FIFO, and a character push from the shift register. The bench provokes this on purpose, and random stimulus also produces it often. The expected result is an empty FIFO with overrun clear, so the push is lost. The bench likewise pushes and pops on a full FIFO in the same cycle and expects the push to be dropped with overrun set. Both outcomes are judged against a bench queue model that applies the flush first, then the pop, then the capacity test on the occupancy from before the pop.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [0:0] {
        MODE_SINGLE = 1'b0,
        MODE_FIFO   = 1'b1
    } mode_t;

    localparam logic [3:0] IID_NONE = 4'h1;
    localparam logic [3:0] IID_RDA  = 4'h4;
    localparam logic [3:0] IID_LINE = 4'h6;

    // trigger select to byte count
    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sio_mode_fsm.sv
module sio_mode_fsm
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic       dma_sel,
    output logic [1:0] trig_sel,
    output logic       rx_flush,
    output logic       tx_flush
);

    mode_t state, state_nxt;
    logic  unused_rsv;

    assign unused_rsv = ^wdata[5:4];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MODE_SINGLE;
        end else begin
            state <= state_nxt;
        end
    end

    // stored fields, updated only by writes that carry bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_sel  <= 1'b0;
            trig_sel <= 2'b00;
        end else if (wr && wdata[0]) begin
            dma_sel  <= wdata[3];
            trig_sel <= wdata[7:6];
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        rx_flush  = 1'b0;
        tx_flush  = 1'b0;
        if (wr) begin
            unique case (state)
                MODE_SINGLE: begin
                    // enter or drop: both empty the FIFOs
                    rx_flush = 1'b1;
                    tx_flush = 1'b1;
                    if (wdata[0]) state_nxt = MODE_FIFO;
                end
                MODE_FIFO: begin
                    if (wdata[0]) begin
                        // reconfigure
                        rx_flush = wdata[1];
                        tx_flush = wdata[2];
                    end else begin
                        // leave
                        rx_flush  = 1'b1;
                        tx_flush  = 1'b1;
                        state_nxt = MODE_SINGLE;
                    end
                end
                default: state_nxt = MODE_SINGLE;
            endcase
        end
    end

    assign fifo_en = (state == MODE_FIFO);

endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          drop
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // fullness is judged on the count before any same-cycle pop
    assign do_push = push && !flush && (count < cap);
    assign do_pop  = pop  && !flush && (count != '0);
    assign drop    = push && !flush && (count >= cap);

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            dout  <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop) begin
                dout <= mem[rptr];
                rptr <= bump(rptr);
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
    import sio_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_flush,
    input  logic          rx_drop,
    input  logic          line_err,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] thr,
    output logic          overrun,
    output logic [3:0]    int_id
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (rx_flush) begin
            overrun <= 1'b0;
        end else if (rx_drop) begin
            overrun <= 1'b1;
        end
    end

    // line status outranks data available
    always_comb begin
        if (overrun || line_err) begin
            int_id = IID_LINE;
        end else if (rx_count >= thr) begin
            int_id = IID_RDA;
        end else begin
            int_id = IID_NONE;
        end
    end

endmodule

// File: rtl/sio_fifo_ctrl.sv
module sio_fifo_ctrl
    import sio_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    output logic [7:0]    ctl_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_din,
    input  logic          rx_line_err,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_dout,
    output logic [CW-1:0] rx_count,
    output logic          rx_overrun,
    output logic          data_ready,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_din,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_dout,
    output logic [CW-1:0] tx_count,
    output logic [3:0]    int_id,
    output logic          dma_mode
);

    logic          fifo_en, dma_sel;
    logic [1:0]    trig_sel;
    logic          rx_flush, tx_flush;
    logic          rx_drop;
    logic          unused_tx_drop;
    logic [CW-1:0] cap, thr;

    sio_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .fifo_en  (fifo_en),
        .dma_sel  (dma_sel),
        .trig_sel (trig_sel),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    assign cap = fifo_en ? CW'(DEPTH) : CW'(1);
    assign thr = fifo_en ? CW'(trig_bytes(trig_sel)) : CW'(1);

    sio_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .cap   (cap),
        .push  (rx_push),
        .din   (rx_din),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .count (rx_count),
        .drop  (rx_drop)
    );

    sio_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .cap   (cap),
        .push  (tx_push),
        .din   (tx_din),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count),
        .drop  (unused_tx_drop)
    );

    sio_irq_prio #(.CW(CW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_flush (rx_flush),
        .rx_drop  (rx_drop),
        .line_err (rx_line_err),
        .rx_count (rx_count),
        .thr      (thr),
        .overrun  (rx_overrun),
        .int_id   (int_id)
    );

    assign ctl_rdata  = {trig_sel, 2'b00, dma_sel, 2'b00, fifo_en};
    assign dma_mode   = fifo_en & dma_sel;
    assign data_ready = (rx_count != '0);

endmodule

// File: rtl/sio_fifo_ctrl_chk.sv
module sio_fifo_ctrl_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic [7:0]    ctl_wdata,
    input logic [7:0]    ctl_rdata,
    input logic          rx_push,
    input logic          rx_line_err,
    input logic          rx_pop,
    input logic [DW-1:0] rx_dout,
    input logic [CW-1:0] rx_count,
    input logic          rx_overrun,
    input logic          data_ready,
    input logic [CW-1:0] tx_count,
    input logic [3:0]    int_id,
    input logic          dma_mode
);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    p_single_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> (rx_count <= CW'(1)) && (tx_count <= CW'(1)));

    p_full_push_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && ctl_rdata[0] && rx_count == CW'(DEPTH) && !ctl_wr) |=> rx_overrun);

    p_leave_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[0]) |=> (rx_count == '0 && tx_count == '0 && !rx_overrun));

    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_count == '0 && !ctl_wr) |=> $stable(rx_dout));

    p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(rx_push));

    p_line_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_line_err |-> int_id == 4'h6);

    p_idle_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_overrun && !rx_line_err && rx_count == '0) |-> int_id == 4'h1);

    p_dma_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode |-> ctl_rdata[0]);

endmodule

bind sio_fifo_ctrl sio_fifo_ctrl_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .rx_push     (rx_push),
    .rx_line_err (rx_line_err),
    .rx_pop      (rx_pop),
    .rx_dout     (rx_dout),
    .rx_count    (rx_count),
    .rx_overrun  (rx_overrun),
    .data_ready  (data_ready),
    .tx_count    (tx_count),
    .int_id      (int_id),
    .dma_mode    (dma_mode)
);

// File: tb/sio_fifo_ctrl_bench.sv
module sio_fifo_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_din = '0;
    logic       rx_line_err = 1'b0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_dout;
    logic [4:0] rx_count;
    logic       rx_overrun;
    logic       data_ready;
    logic       tx_push = 1'b0;
    logic [7:0] tx_din = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_dout;
    logic [4:0] tx_count;
    logic [3:0] int_id;
    logic       dma_mode;

    always #2 clk = ~clk;

    sio_fifo_ctrl u_sio_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .rx_push(rx_push), .rx_din(rx_din),
        .rx_line_err(rx_line_err), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .rx_count(rx_count), .rx_overrun(rx_overrun), .data_ready(data_ready),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
        .tx_count(tx_count), .int_id(int_id), .dma_mode(dma_mode)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // reference model state
    logic [7:0] mrx[$];
    logic [7:0] mtx[$];
    bit         m_fen = 0, m_dma = 0, m_ovr = 0, m_le = 0;
    logic [1:0] m_trig = 0;
    logic [7:0] m_rxd = 0, m_txd = 0;

    function automatic int lvl(input bit fen, input logic [1:0] t);
        if (!fen) return 1;
        case (t)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] exp_id();
        if (m_ovr || m_le) return 4'h6;
        if (mrx.size() >= lvl(m_fen, m_trig)) return 4'h4;
        return 4'h1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 ctl_rdata", 32'(ctl_rdata), 32'({m_trig, 2'b00, m_dma, 2'b00, m_fen}));
        chk("R5 rx_count", 32'(rx_count), 32'(mrx.size()));
        chk("R5 tx_count", 32'(tx_count), 32'(mtx.size()));
        chk("R5 rx_overrun", 32'(rx_overrun), 32'(m_ovr));
        chk("R6 rx_dout", 32'(rx_dout), 32'(m_rxd));
        chk("R6 tx_dout", 32'(tx_dout), 32'(m_txd));
        chk("R7 data_ready", 32'(data_ready), 32'(mrx.size() != 0));
        chk("R8/R9 int_id", 32'(int_id), 32'(exp_id()));
        chk("R10 dma_mode", 32'(dma_mode), 32'(m_fen & m_dma));
    endtask

    task automatic step(input bit wr, input logic [7:0] wd, input bit rp, input logic [7:0] rd,
                        input bit rpo, input bit tp, input logic [7:0] td, input bit tpo,
                        input bit le);
        int cap;
        bit rxf;
        bit txf;
        int pre;
        @(negedge clk);
        ctl_wr = wr; ctl_wdata = wd; rx_push = rp; rx_din = rd; rx_pop = rpo;
        tx_push = tp; tx_din = td; tx_pop = tpo; rx_line_err = le;
        cap = m_fen ? 16 : 1;
        rxf = 0;
        txf = 0;
        if (wr) begin
            if (wd[0]) begin
                if (!m_fen) begin rxf = 1; txf = 1; end
                if (wd[1]) rxf = 1;
                if (wd[2]) txf = 1;
                m_fen = 1; m_dma = wd[3]; m_trig = wd[7:6];
            end else begin
                rxf = 1; txf = 1; m_fen = 0;
            end
        end
        if (rxf) begin
            mrx.delete(); m_ovr = 0;
        end else begin
            pre = mrx.size();
            if (rpo && pre > 0) m_rxd = mrx.pop_front();
            if (rp) begin
                if (pre < cap) mrx.push_back(rd);
                else m_ovr = 1;
            end
        end
        if (txf) begin
            mtx.delete();
        end else begin
            pre = mtx.size();
            if (tpo && pre > 0) m_txd = mtx.pop_front();
            if (tp && pre < cap) mtx.push_back(td);
        end
        m_le = le;
        @(posedge clk);
        #1;
        check_all();
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        step(1, v, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rxp(input logic [7:0] d);
        step(0, 0, 1, d, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7321);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctl_rdata", 32'(ctl_rdata), 0);
        chk("R1 rx_count", 32'(rx_count), 0);
        chk("R1 tx_count", 32'(tx_count), 0);
        chk("R1 int_id", 32'(int_id), 1);
        chk("R1 flags", 32'({data_ready, rx_overrun, dma_mode}), 0);

        // R2 enable FIFO mode, trigger 4 bytes
        wr_ctl(8'h41);
        chk("R2 readback", 32'(ctl_rdata), 32'h41);
        // R8 trigger crossing at 4
        for (int i = 0; i < 3; i++) rxp(8'(8'h10 + i));
        chk("R8 below trigger", 32'(int_id), 1);
        rxp(8'h13);
        chk("R8 at trigger", 32'(int_id), 4);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 oldest first", 32'(rx_dout), 32'h10);
        chk("R8 below again", 32'(int_id), 1);
        // R5 fill and overrun
        for (int i = 0; i < 14; i++) rxp(8'(8'h20 + i));
        chk("R5 full count", 32'(rx_count), 16);
        chk("R5 overrun set", 32'(rx_overrun), 1);
        chk("R9 line status", 32'(int_id), 6);
        // R4 clear rx only, tx keeps data
        step(0, 0, 0, 0, 0, 1, 8'hA5, 0, 0);
        wr_ctl(8'hC7 & 8'hC3);
        chk("R4 rx emptied", 32'(rx_count), 0);
        chk("R4 tx kept", 32'(tx_count), 1);
        chk("R4 bits 1,2 read 0", 32'(ctl_rdata[2:1]), 0);
        chk("R4 overrun cleared", 32'(rx_overrun), 0);
        wr_ctl(8'hC5);
        chk("R4 tx emptied", 32'(tx_count), 0);
        // R11 push and pop on full
        for (int i = 0; i < 16; i++) rxp(8'(8'h40 + i));
        step(0, 0, 1, 8'hEE, 1, 0, 0, 0, 0);
        chk("R11 full push dropped", 32'(rx_count), 15);
        chk("R11 overrun on full push", 32'(rx_overrun), 1);
        // R11 clear and push in one cycle
        step(1, 8'h03, 1, 8'h77, 0, 0, 0, 0, 0);
        chk("R11 flush beats push", 32'(rx_count), 0);
        // R6 pop on empty
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 empty pop holds", 32'(rx_dout), 32'h40);
        // R9 external line error
        rxp(8'h01);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9 line err outranks", 32'(int_id), 6);
        // R10 DMA select, then leave FIFO mode (R3)
        wr_ctl(8'hC9);
        chk("R10 dma on", 32'(dma_mode), 1);
        rxp(8'h02);
        step(0, 0, 0, 0, 0, 1, 8'h5A, 0, 0);
        wr_ctl(8'h00);
        chk("R3 rx flushed", 32'(rx_count), 0);
        chk("R3 tx flushed", 32'(tx_count), 0);
        chk("R2 fields kept", 32'(ctl_rdata), 32'hC8);
        chk("R10 dma off in single", 32'(dma_mode), 0);
        // R5 single-byte capacity, R8 trigger fixed at 1
        rxp(8'h31);
        chk("R8 single trigger", 32'(int_id), 4);
        rxp(8'h32);
        chk("R5 single cap", 32'(rx_count), 1);
        chk("R5 single overrun", 32'(rx_overrun), 1);
        // R3 entering FIFO mode flushes
        wr_ctl(8'h81);
        chk("R3 enter flush", 32'(rx_count), 0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            bit wr;
            logic [7:0] wd;
            wr = ($urandom_range(99) < 4);
            wd = 8'($urandom());
            if ($urandom_range(9) != 0) wd[0] = 1'b1;
            step(wr, wd, ($urandom_range(99) < 50), 8'($urandom()),
                 ($urandom_range(99) < 35), ($urandom_range(99) < 45), 8'($urandom()),
                 ($urandom_range(99) < 40), ($urandom_range(99) < 5));
        end
        idle();
        finish_run();
    end

endmodule